// File: doc/BRIEF.md
# Entry Call/Accept Rendezvous Matcher

This unit pairs callers with server tasks on a small set of numbered entry points. Each message names an entry and carries a thread-state handle. It is one of four kinds: a call, a blocking accept, a non-blocking try-accept, or a finish notice for that entry. Every entry has one FIFO that holds whichever side got there first. A type bit records whether the FIFO currently holds callers or servers. An arrival of the other side takes the oldest waiting item and forms a pair.

A pair may begin only when its entry has no rendezvous in progress. The unit then pulses a start request that carries the entry and both handles. If the entry is busy, the new pair is parked in a single per-entry slot. When the finish notice arrives, the caller and server of the running rendezvous are released together. In that same cycle the parked pair, if there is one, is started. Rejections are reported through their own responses: a try-accept that finds no caller, a message that cannot be stored, and a finish notice for an idle entry.

The block accepts one message per clock. Every response is registered and appears exactly one cycle after the message.

Top module: `rdv_matcher`

## Requirements
- R1: After reset every output valid and done_err are low, and all entries are idle with empty queues.
- R2: msg_kind 0 is a call. A call that finds no waiting server is appended to its entry's queue. Waiting callers are paired oldest first.
- R3: msg_kind 1 is a blocking accept. A blocking accept that finds no waiting caller is appended to the queue, which then holds servers. Waiting servers are paired oldest first.
- R4: An arrival that finds the opposite kind at its queue head takes that head, and the pair is formed. If the entry is idle, start_valid pulses one cycle after the message, with start_entry, start_caller and start_server.
- R5: An entry never has two rendezvous at once. A pair formed while the entry is active is parked in a one-pair slot. That pair is started in the cycle of the release that frees the entry.
- R6: msg_kind 3 is a finish notice. For an active entry it pulses rel_valid one cycle later, with rel_entry and both handles of the running rendezvous.
- R7: msg_kind 2 is a try-accept. If no caller is waiting, it pulses nocall_valid with resp_handle equal to its handle, and nothing is queued.
- R8: A finish notice for an idle entry pulses done_err, and the entry's state is left unchanged.
- R9: busy_valid pulses, with resp_handle equal to the message handle, and the queue and slot are left unchanged, when a message would need to be stored and there is no room. This covers a queue arrival that finds the queue full, and a pair formed while the parked slot is already taken.
- R10: At most one of start_valid, nocall_valid, busy_valid and done_err is high in any cycle. rel_valid appears only with start_valid, never with the others. With no message in a cycle, all of them are low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| msg_valid | input | 1 | A message is presented this cycle |
| msg_kind | input | 2 | 0 call, 1 blocking accept, 2 try-accept, 3 finish |
| msg_entry | input | clog2(NUM_ENTRIES) | Target entry index |
| msg_handle | input | HANDLE_W | Thread-state handle of the sender |
| start_valid | output | 1 | Start request for a rendezvous |
| start_entry | output | clog2(NUM_ENTRIES) | Entry being started |
| start_caller | output | HANDLE_W | Caller handle of the started pair |
| start_server | output | HANDLE_W | Server handle of the started pair |
| rel_valid | output | 1 | Joint release of caller and server |
| rel_entry | output | clog2(NUM_ENTRIES) | Entry being released |
| rel_caller | output | HANDLE_W | Released caller handle |
| rel_server | output | HANDLE_W | Released server handle |
| nocall_valid | output | 1 | Try-accept found no caller |
| busy_valid | output | 1 | Message rejected for lack of room |
| resp_handle | output | HANDLE_W | Handle of the message answered by nocall or busy |
| done_err | output | 1 | Finish notice for an idle entry |

## Verification
Two events can fall in the same cycle. A finish notice releases the running pair, and it also starts the pair that was parked during that rendezvous. The bench provokes this by forming a second pair on an entry that is still active, then sending the finish notice. Random sweeps repeat the situation many times across all entries. A check passes only if one registered cycle shows rel_valid and start_valid together on the same entry, with the old handles on the release side and the parked handles on the start side.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
    typedef enum logic [1:0] {
        K_CALL = 2'd0,
        K_ACC  = 2'd1,
        K_TRY  = 2'd2,
        K_DONE = 2'd3
    } msg_kind_e;
endpackage

// File: rtl/rdv_fifo.sv
module rdv_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fq_t;

    fq_t q_q, q_d;
    logic [PW:0] wr_sum;
    logic        push_ok, pop_ok;

    assign empty = (q_q.cnt == '0);
    assign full  = (q_q.cnt == CW'(DEPTH));
    assign head  = q_q.mem[q_q.rd];

    always_comb begin
        q_d     = q_q;
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        wr_sum  = {1'b0, q_q.rd} + (PW+1)'(q_q.cnt);
        if (wr_sum >= (PW+1)'(DEPTH))
            wr_sum = wr_sum - (PW+1)'(DEPTH);
        if (push_ok)
            q_d.mem[wr_sum[PW-1:0]] = din;
        if (pop_ok)
            q_d.rd = (q_q.rd == PW'(DEPTH-1)) ? '0 : q_q.rd + 1'b1;
        if (push_ok && !pop_ok)
            q_d.cnt = q_q.cnt + 1'b1;
        else if (pop_ok && !push_ok)
            q_d.cnt = q_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end
endmodule

// File: rtl/rdv_entry.sv
module rdv_entry
    import rdv_pkg::*;
#(
    parameter int QUEUE_DEPTH = 4,
    parameter int HANDLE_W    = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  msg_kind_e           kind,
    input  logic [HANDLE_W-1:0] handle,
    output logic                ev_start,
    output logic [HANDLE_W-1:0] st_caller,
    output logic [HANDLE_W-1:0] st_server,
    output logic                ev_rel,
    output logic [HANDLE_W-1:0] rl_caller,
    output logic [HANDLE_W-1:0] rl_server,
    output logic                ev_nocall,
    output logic                ev_busy,
    output logic                ev_err
);
    typedef struct packed {
        logic                holds_acc;
        logic                active;
        logic                pend_v;
        logic [HANDLE_W-1:0] act_c;
        logic [HANDLE_W-1:0] act_s;
        logic [HANDLE_W-1:0] pend_c;
        logic [HANDLE_W-1:0] pend_s;
    } ent_t;

    ent_t st_q, st_d;
    logic                push, pop, empty, full;
    logic [HANDLE_W-1:0] q_head;
    logic                match;
    logic [HANDLE_W-1:0] m_c, m_s;
    logic                has_call, has_acc;

    rdv_fifo #(.DEPTH(QUEUE_DEPTH), .W(HANDLE_W)) u_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .pop   (pop),
        .din   (handle),
        .head  (q_head),
        .empty (empty),
        .full  (full)
    );

    assign has_call = !empty && !st_q.holds_acc;
    assign has_acc  = !empty &&  st_q.holds_acc;

    always_comb begin
        st_d      = st_q;
        push      = 1'b0;
        pop       = 1'b0;
        match     = 1'b0;
        m_c       = '0;
        m_s       = '0;
        ev_start  = 1'b0;
        st_caller = '0;
        st_server = '0;
        ev_rel    = 1'b0;
        rl_caller = '0;
        rl_server = '0;
        ev_nocall = 1'b0;
        ev_busy   = 1'b0;
        ev_err    = 1'b0;

        if (sel) begin
            unique case (kind)
                K_CALL: begin
                    if (has_acc) begin
                        match = 1'b1; m_c = handle; m_s = q_head;
                    end else if (full) begin
                        ev_busy = 1'b1;
                    end else begin
                        push = 1'b1; st_d.holds_acc = 1'b0;
                    end
                end
                K_ACC: begin
                    if (has_call) begin
                        match = 1'b1; m_c = q_head; m_s = handle;
                    end else if (full) begin
                        ev_busy = 1'b1;
                    end else begin
                        push = 1'b1; st_d.holds_acc = 1'b1;
                    end
                end
                K_TRY: begin
                    if (has_call) begin
                        match = 1'b1; m_c = q_head; m_s = handle;
                    end else begin
                        ev_nocall = 1'b1;
                    end
                end
                K_DONE: begin
                    if (st_q.active) begin
                        ev_rel    = 1'b1;
                        rl_caller = st_q.act_c;
                        rl_server = st_q.act_s;
                        if (st_q.pend_v) begin
                            ev_start    = 1'b1;
                            st_caller   = st_q.pend_c;
                            st_server   = st_q.pend_s;
                            st_d.act_c  = st_q.pend_c;
                            st_d.act_s  = st_q.pend_s;
                            st_d.pend_v = 1'b0;
                        end else begin
                            st_d.active = 1'b0;
                        end
                    end else begin
                        ev_err = 1'b1;
                    end
                end
                default: ;
            endcase
        end

        if (match) begin
            if (!st_q.active) begin
                pop         = 1'b1;
                ev_start    = 1'b1;
                st_caller   = m_c;
                st_server   = m_s;
                st_d.active = 1'b1;
                st_d.act_c  = m_c;
                st_d.act_s  = m_s;
            end else if (!st_q.pend_v) begin
                pop         = 1'b1;
                st_d.pend_v = 1'b1;
                st_d.pend_c = m_c;
                st_d.pend_s = m_s;
            end else begin
                ev_busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rdv_matcher.sv
module rdv_matcher
    import rdv_pkg::*;
#(
    parameter int NUM_ENTRIES = 4,
    parameter int QUEUE_DEPTH = 4,
    parameter int HANDLE_W    = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           msg_valid,
    input  logic [1:0]                     msg_kind,
    input  logic [$clog2(NUM_ENTRIES)-1:0] msg_entry,
    input  logic [HANDLE_W-1:0]            msg_handle,
    output logic                           start_valid,
    output logic [$clog2(NUM_ENTRIES)-1:0] start_entry,
    output logic [HANDLE_W-1:0]            start_caller,
    output logic [HANDLE_W-1:0]            start_server,
    output logic                           rel_valid,
    output logic [$clog2(NUM_ENTRIES)-1:0] rel_entry,
    output logic [HANDLE_W-1:0]            rel_caller,
    output logic [HANDLE_W-1:0]            rel_server,
    output logic                           nocall_valid,
    output logic                           busy_valid,
    output logic [HANDLE_W-1:0]            resp_handle,
    output logic                           done_err
);
    localparam int EW = $clog2(NUM_ENTRIES);

    typedef struct packed {
        logic                start_v;
        logic [EW-1:0]       start_e;
        logic [HANDLE_W-1:0] start_c;
        logic [HANDLE_W-1:0] start_s;
        logic                rel_v;
        logic [EW-1:0]       rel_e;
        logic [HANDLE_W-1:0] rel_c;
        logic [HANDLE_W-1:0] rel_s;
        logic                nocall_v;
        logic                busy_v;
        logic [HANDLE_W-1:0] resp_h;
        logic                err;
    } out_t;

    out_t out_q, out_d;
    msg_kind_e kind;

    logic [NUM_ENTRIES-1:0] e_start, e_rel, e_nocall, e_busy, e_err;
    logic [HANDLE_W-1:0]    e_sc [NUM_ENTRIES];
    logic [HANDLE_W-1:0]    e_ss [NUM_ENTRIES];
    logic [HANDLE_W-1:0]    e_rc [NUM_ENTRIES];
    logic [HANDLE_W-1:0]    e_rs [NUM_ENTRIES];

    assign kind = msg_kind_e'(msg_kind);

    for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
        rdv_entry #(.QUEUE_DEPTH(QUEUE_DEPTH), .HANDLE_W(HANDLE_W)) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .sel       (msg_valid && (msg_entry == EW'(i))),
            .kind      (kind),
            .handle    (msg_handle),
            .ev_start  (e_start[i]),
            .st_caller (e_sc[i]),
            .st_server (e_ss[i]),
            .ev_rel    (e_rel[i]),
            .rl_caller (e_rc[i]),
            .rl_server (e_rs[i]),
            .ev_nocall (e_nocall[i]),
            .ev_busy   (e_busy[i]),
            .ev_err    (e_err[i])
        );
    end

    always_comb begin
        out_d          = '0;
        out_d.nocall_v = |e_nocall;
        out_d.busy_v   = |e_busy;
        out_d.err      = |e_err;
        if (out_d.nocall_v || out_d.busy_v)
            out_d.resp_h = msg_handle;
        for (int i = 0; i < NUM_ENTRIES; i++) begin
            if (e_start[i]) begin
                out_d.start_v = 1'b1;
                out_d.start_e = EW'(i);
                out_d.start_c = e_sc[i];
                out_d.start_s = e_ss[i];
            end
            if (e_rel[i]) begin
                out_d.rel_v = 1'b1;
                out_d.rel_e = EW'(i);
                out_d.rel_c = e_rc[i];
                out_d.rel_s = e_rs[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign start_valid  = out_q.start_v;
    assign start_entry  = out_q.start_e;
    assign start_caller = out_q.start_c;
    assign start_server = out_q.start_s;
    assign rel_valid    = out_q.rel_v;
    assign rel_entry    = out_q.rel_e;
    assign rel_caller   = out_q.rel_c;
    assign rel_server   = out_q.rel_s;
    assign nocall_valid = out_q.nocall_v;
    assign busy_valid   = out_q.busy_v;
    assign resp_handle  = out_q.resp_h;
    assign done_err     = out_q.err;
endmodule

// File: rtl/rdv_matcher_chk.sv
module rdv_matcher_chk #(
    parameter int NUM_ENTRIES = 4,
    parameter int HANDLE_W    = 8
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           msg_valid,
    input logic [1:0]                     msg_kind,
    input logic [$clog2(NUM_ENTRIES)-1:0] msg_entry,
    input logic [HANDLE_W-1:0]            msg_handle,
    input logic                           start_valid,
    input logic [$clog2(NUM_ENTRIES)-1:0] start_entry,
    input logic                           rel_valid,
    input logic [$clog2(NUM_ENTRIES)-1:0] rel_entry,
    input logic                           nocall_valid,
    input logic                           busy_valid,
    input logic [HANDLE_W-1:0]            resp_handle,
    input logic                           done_err
);
    logic [NUM_ENTRIES-1:0] seen_act_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_act_q <= '0;
        end else begin
            if (rel_valid)   seen_act_q[rel_entry]   <= 1'b0;
            if (start_valid) seen_act_q[start_entry] <= 1'b1;
        end
    end

    AST_FRESH_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && !rel_valid) |-> !seen_act_q[start_entry]); // R5
    AST_HANDOFF_SAME_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_valid && rel_valid) |-> (start_entry == rel_entry)); // R5
    AST_REL_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> seen_act_q[rel_entry]); // R6
    AST_REL_FROM_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> ($past(msg_valid) && $past(msg_kind) == 2'd3)); // R6
    AST_ERR_FROM_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> ($past(msg_valid) && $past(msg_kind) == 2'd3)); // R8
    AST_NOCALL_FROM_TRY: assert property (@(posedge clk) disable iff (!rst_n)
        nocall_valid |-> ($past(msg_valid) && $past(msg_kind) == 2'd2)); // R7
    AST_RESP_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (nocall_valid || busy_valid) |-> (resp_handle == $past(msg_handle))); // R9
    AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_valid, nocall_valid, busy_valid, done_err})); // R10
    AST_REL_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
        rel_valid |-> !(nocall_valid || busy_valid || done_err)); // R10
    AST_QUIET_NO_MSG: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |=> !(start_valid || rel_valid || nocall_valid || busy_valid || done_err)); // R10
endmodule

bind rdv_matcher rdv_matcher_chk #(.NUM_ENTRIES(NUM_ENTRIES), .HANDLE_W(HANDLE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .msg_valid    (msg_valid),
    .msg_kind     (msg_kind),
    .msg_entry    (msg_entry),
    .msg_handle   (msg_handle),
    .start_valid  (start_valid),
    .start_entry  (start_entry),
    .rel_valid    (rel_valid),
    .rel_entry    (rel_entry),
    .nocall_valid (nocall_valid),
    .busy_valid   (busy_valid),
    .resp_handle  (resp_handle),
    .done_err     (done_err)
);

// File: tb/tb_rdv_matcher.sv
`timescale 1ns/1ps
module tb_rdv_matcher;
    localparam int NE = 4;
    localparam int QD = 3;
    localparam int HW = 8;
    localparam int EW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          msg_valid = 1'b0;
    logic [1:0]    msg_kind = '0;
    logic [EW-1:0] msg_entry = '0;
    logic [HW-1:0] msg_handle = '0;
    logic          start_valid, rel_valid, nocall_valid, busy_valid, done_err;
    logic [EW-1:0] start_entry, rel_entry;
    logic [HW-1:0] start_caller, start_server, rel_caller, rel_server, resp_handle;

    always #2 clk = ~clk;

    rdv_matcher #(.NUM_ENTRIES(NE), .QUEUE_DEPTH(QD), .HANDLE_W(HW)) dut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_kind(msg_kind),
        .msg_entry(msg_entry), .msg_handle(msg_handle),
        .start_valid(start_valid), .start_entry(start_entry),
        .start_caller(start_caller), .start_server(start_server),
        .rel_valid(rel_valid), .rel_entry(rel_entry),
        .rel_caller(rel_caller), .rel_server(rel_server),
        .nocall_valid(nocall_valid), .busy_valid(busy_valid),
        .resp_handle(resp_handle), .done_err(done_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Reference state derived from the requirements
    int  q_h [NE][QD];
    int  q_n [NE];
    bit  q_acc [NE];
    bit  m_act [NE];
    int  m_ac [NE];
    int  m_as [NE];
    bit  m_pv [NE];
    int  m_pc [NE];
    int  m_ps [NE];

    // Expected outputs for the current message
    bit x_st, x_rel, x_nc, x_busy, x_err;
    int x_se, x_sc, x_ss, x_re, x_rc, x_rs, x_resp;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int qpop(input int e);
        int h = q_h[e][0];
        for (int i = 0; i < QD-1; i++) q_h[e][i] = q_h[e][i+1];
        q_n[e]--;
        return h;
    endfunction

    task automatic model(input int k, input int e, input int h);
        bit mt;
        int mc, ms;
        mt = 0; mc = 0; ms = 0;
        x_st = 0; x_rel = 0; x_nc = 0; x_busy = 0; x_err = 0;
        x_resp = h;
        case (k)
            0: begin // R2 call
                if (q_n[e] > 0 && q_acc[e]) begin mt = 1; mc = h; ms = q_h[e][0]; end
                else if (q_n[e] == QD) x_busy = 1;
                else begin q_h[e][q_n[e]] = h; q_n[e]++; q_acc[e] = 0; end
            end
            1: begin // R3 blocking accept
                if (q_n[e] > 0 && !q_acc[e]) begin mt = 1; mc = q_h[e][0]; ms = h; end
                else if (q_n[e] == QD) x_busy = 1;
                else begin q_h[e][q_n[e]] = h; q_n[e]++; q_acc[e] = 1; end
            end
            2: begin // R7 try-accept
                if (q_n[e] > 0 && !q_acc[e]) begin mt = 1; mc = q_h[e][0]; ms = h; end
                else x_nc = 1;
            end
            default: begin // R6 / R8 finish
                if (m_act[e]) begin
                    x_rel = 1; x_re = e; x_rc = m_ac[e]; x_rs = m_as[e];
                    if (m_pv[e]) begin
                        x_st = 1; x_se = e; x_sc = m_pc[e]; x_ss = m_ps[e];
                        m_ac[e] = m_pc[e]; m_as[e] = m_ps[e]; m_pv[e] = 0;
                    end else m_act[e] = 0;
                end else x_err = 1;
            end
        endcase
        if (mt) begin
            if (!m_act[e]) begin
                void'(qpop(e));
                x_st = 1; x_se = e; x_sc = mc; x_ss = ms;
                m_act[e] = 1; m_ac[e] = mc; m_as[e] = ms;
            end else if (!m_pv[e]) begin
                void'(qpop(e));
                m_pv[e] = 1; m_pc[e] = mc; m_ps[e] = ms;
            end else x_busy = 1; // R9 slot taken
        end
    endtask

    task automatic compare();
        chk(start_valid == x_st, "R4/R5 start_valid", start_valid, x_st);
        if (x_st && start_valid) begin
            chk(start_entry == x_se, "R4 start_entry", start_entry, x_se);
            chk(start_caller == x_sc, "R2/R4 start_caller", start_caller, x_sc);
            chk(start_server == x_ss, "R3/R4 start_server", start_server, x_ss);
        end
        chk(rel_valid == x_rel, "R6 rel_valid", rel_valid, x_rel);
        if (x_rel && rel_valid) begin
            chk(rel_entry == x_re, "R6 rel_entry", rel_entry, x_re);
            chk(rel_caller == x_rc, "R6 rel_caller", rel_caller, x_rc);
            chk(rel_server == x_rs, "R6 rel_server", rel_server, x_rs);
        end
        chk(nocall_valid == x_nc, "R7 nocall_valid", nocall_valid, x_nc);
        chk(busy_valid == x_busy, "R9 busy_valid", busy_valid, x_busy);
        if (x_nc || x_busy)
            chk(resp_handle == x_resp, "R7/R9 resp_handle", resp_handle, x_resp);
        chk(done_err == x_err, "R8 done_err", done_err, x_err);
    endtask

    task automatic send(input int k, input int e, input int h);
        msg_valid = 1; msg_kind = 2'(k); msg_entry = EW'(e); msg_handle = HW'(h);
        model(k, e, h);
        @(posedge clk);
        @(negedge clk);
        msg_valid = 0;
        compare();
    endtask

    task automatic idle();
        msg_valid = 0;
        x_st = 0; x_rel = 0; x_nc = 0; x_busy = 0; x_err = 0;
        @(posedge clk);
        @(negedge clk);
        compare(); // R10 quiet without messages
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        for (int e = 0; e < NE; e++) begin
            q_n[e] = 0; q_acc[e] = 0; m_act[e] = 0; m_pv[e] = 0;
            m_ac[e] = 0; m_as[e] = 0; m_pc[e] = 0; m_ps[e] = 0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!(start_valid || rel_valid || nocall_valid || busy_valid || done_err),
            "R1 outputs idle in reset", 1, 0);
        rst_n = 1;
        idle();

        send(3, 0, 8'h11);          // R8 finish on idle entry
        send(2, 0, 8'h12);          // R7 try-accept, no caller
        send(0, 0, 8'hA1);          // R2 calls queue up
        send(0, 0, 8'hA2);
        send(0, 0, 8'hA3);
        send(0, 0, 8'hA4);          // R9 queue full
        send(1, 0, 8'hB1);          // R4 match with oldest caller A1
        send(2, 0, 8'hB2);          // R5 parked pair A2/B2
        send(1, 0, 8'hB3);          // R9 slot taken, A3 stays
        send(3, 0, 8'h00);          // R5/R6 release A1/B1, start A2/B2
        send(3, 0, 8'h00);          // R6 release A2/B2
        send(3, 0, 8'h00);          // R8 now idle
        send(1, 0, 8'hB4);          // R4 A3 with B4
        send(3, 0, 8'h00);
        send(1, 1, 8'hC1);          // R3 accepts queue
        send(1, 1, 8'hC2);
        send(2, 1, 8'hC3);          // R7 accepts queued, still no caller
        send(0, 1, 8'hD1);          // R3 oldest server C1
        send(0, 1, 8'hD2);          // R5 parked D2/C2
        send(3, 1, 8'h00);          // R5 handoff
        send(3, 1, 8'h00);
        idle();

        // Near-exhaustive pseudo-random sweep over all kinds and entries
        lfsr = 16'hACE1;
        for (int n = 0; n < 6000; n++) begin
            int k, e, h;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            k = int'(lfsr[1:0]);
            e = int'(lfsr[4:3]);
            h = int'(lfsr[12:5]);
            if (lfsr[15:14] == 2'b00 && n[3:0] == 4'd0) idle();
            else send(k, e, h);
        end
        idle();

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule